// File: doc/BRIEF.md
# Bank-Interleaved Crosspoint Cache Slice

This block is one cache placed where a processor's private bus crosses the bus of one memory bank. Memory is interleaved across banks on the two address bits just above the word offset. Each processor therefore reaches a given address through exactly one slice, and this slice holds only lines of its own bank. The cache is direct mapped: 1024 lines of four 32-bit words. Each line has a tag, a valid bit and a shared bit. The processor side needs no arbitration because only its owning processor drives it. The memory side uses a request/grant handshake and also carries snooped traffic from the other slices on the same bank.

A request is taken in `IDLE` and moves to `LOOKUP`. From `LOOKUP` the controller takes one of two paths:
- It goes to `DONE` on a read hit, or on a write hit to an unshared line.
- It goes to `BUSREQ` on a miss, or on a write hit to a shared line.

`BUSREQ` holds the request until grant. After grant it goes to `FILL` for a line fill, or to `DONE` for a word write. `FILL` takes four beats and then goes to `DONE`. `DONE` pulses ready and returns to `IDLE`.

A snooped write by another cache to a resident line clears that line's valid bit. A snooped fill of a resident line marks the line shared.

Top module: `xpc_slice`

## Requirements
- R1: After reset every line is invalid, and `cpu_ready`, `cpu_stall` and `mb_req` are low.
- R2: A request is ignored when its address bits [5:4] differ from `BANK_ID`. Ignored means no ready, no stall, no bus request, and no change to any line.
- R3: A read hit returns the addressed word with a one-cycle `cpu_ready` pulse on the second rising edge after the edge that took the request. `cpu_stall` is high in between.
- R4: A read miss raises `mb_req` with `mb_cmd`=0 (line fill) and the line address (bits [3:0] zero). `mb_req` stays high until the edge where `mb_gnt` is seen.
- R5: A fill takes four `mb_rvalid` beats, for words 0,1,2,3 in that order, and may have gaps between beats. The slice stores every beat and returns the requested word. The line becomes valid with the new tag.
- R6: A write hit to an unshared line updates the word locally and issues no bus request. Ready follows with the same timing as a read hit.
- R7: A write hit to a shared line updates the word and issues `mb_cmd`=1 (word write) with the word-aligned address and the data. After grant the line is unshared.
- R8: A write miss issues a word write on the bus and allocates no line.
- R9: The shared bit takes the value of `mb_rshared` on the last fill beat. A snooped fill (`snp_write`=0) that hits a resident line sets the bit.
- R10: A snooped write (`snp_write`=1) whose tag and index match a valid line invalidates that line. A snoop with a different tag has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor request strobe, sampled in IDLE |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_stall | output | 1 | Not-ready while a request is in progress |
| mb_req | output | 1 | Memory bus request, held until grant |
| mb_gnt | input | 1 | Memory bus grant |
| mb_cmd | output | 1 | 0 = line fill, 1 = word write |
| mb_addr | output | 32 | Bus address |
| mb_wdata | output | 32 | Bus write data |
| mb_rvalid | input | 1 | Fill beat valid |
| mb_rdata | input | 32 | Fill beat data |
| mb_rshared | input | 1 | Line held elsewhere, sampled on the last beat |
| snp_valid | input | 1 | Snooped transaction from another cache |
| snp_write | input | 1 | 1 = snooped write, 0 = snooped fill |
| snp_addr | input | 32 | Snooped address |

## Verification
Hits finish on a fixed schedule. The request is taken on one edge, the lookup occupies the next cycle, and ready is due on the falling edge after the second rising edge. The bench requires exactly that latency for every access that stays off the bus.

Bus accesses have no fixed latency, because the grant delay and fill gaps come from the bench's memory model. For these, ready is due one cycle after the grant edge (word write) or after the edge that takes the last beat (fill). The bench checks the command, address and data it sees on the bus.

All outputs are sampled on falling edges. After each completion the bench looks one cycle later to confirm that ready has dropped.

// File: rtl/xpc_pkg.sv
package xpc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_BUSREQ,
        ST_FILL,
        ST_DONE
    } xpc_state_e;

    typedef enum logic {
        MB_FILL  = 1'b0,
        MB_WRITE = 1'b1
    } mb_cmd_e;

endpackage

// File: rtl/xpc_addr_split.sv
module xpc_addr_split #(
    parameter int ADDR_W     = 32,
    parameter int BYTE_BITS  = 2,
    parameter int WORD_BITS  = 2,
    parameter int BANK_BITS  = 2,
    parameter int INDEX_BITS = 10,
    parameter int TAG_W      = 16,
    parameter int BANK_ID    = 0
) (
    input  logic [ADDR_W-1:0]     addr,
    output logic                  bank_hit,
    output logic [WORD_BITS-1:0]  word,
    output logic [INDEX_BITS-1:0] index,
    output logic [TAG_W-1:0]      tag
);
    localparam int WORD_LO  = BYTE_BITS;
    localparam int BANK_LO  = WORD_LO + WORD_BITS;
    localparam int INDEX_LO = BANK_LO + BANK_BITS;
    localparam int TAG_LO   = INDEX_LO + INDEX_BITS;

    logic byte_sel_unused;

    assign byte_sel_unused = ^addr[BYTE_BITS-1:0];
    assign bank_hit = (addr[BANK_LO +: BANK_BITS] == BANK_BITS'(BANK_ID));
    assign word     = addr[WORD_LO +: WORD_BITS];
    assign index    = addr[INDEX_LO +: INDEX_BITS];
    assign tag      = addr[TAG_LO +: TAG_W];
endmodule

// File: rtl/xpc_tag_store.sv
module xpc_tag_store #(
    parameter int INDEX_BITS = 10,
    parameter int TAG_W      = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [INDEX_BITS-1:0] rd_idx,
    output logic [TAG_W-1:0]      rd_tag,
    output logic                  rd_valid,
    output logic                  rd_shared,
    input  logic                  fill_en,
    input  logic [TAG_W-1:0]      fill_tag,
    input  logic                  fill_shared,
    input  logic                  clr_en,
    input  logic                  snp_en,
    input  logic                  snp_write,
    input  logic [INDEX_BITS-1:0] snp_idx,
    input  logic [TAG_W-1:0]      snp_tag
);
    localparam int LINES = 1 << INDEX_BITS;

    logic [TAG_W-1:0] tags [LINES];
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] shared_q;
    logic             snp_hit;

    assign rd_tag    = tags[rd_idx];
    assign rd_valid  = valid_q[rd_idx];
    assign rd_shared = shared_q[rd_idx];
    assign snp_hit   = snp_en && valid_q[snp_idx] && (tags[snp_idx] == snp_tag);

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tags[rd_idx] <= fill_tag;
        end
    end

    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[i]  <= 1'b0;
                shared_q[i] <= 1'b0;
            end else begin
                if (fill_en && rd_idx == INDEX_BITS'(i)) begin
                    valid_q[i]  <= 1'b1;
                    shared_q[i] <= fill_shared;
                end
                if (clr_en && rd_idx == INDEX_BITS'(i)) begin
                    shared_q[i] <= 1'b0;
                end
                if (snp_hit && snp_idx == INDEX_BITS'(i)) begin
                    if (snp_write) begin
                        valid_q[i] <= 1'b0;
                    end else begin
                        shared_q[i] <= 1'b1;
                    end
                end
            end
        end
    end

    // R10: a snooped write hit leaves that line invalid
    a_r10_snoop_write_kills: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_hit && snp_write) |=> !valid_q[$past(snp_idx)]);

    // R9: a snooped fill hit leaves that line shared
    a_r9_snoop_read_shares: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_hit && !snp_write) |=> shared_q[$past(snp_idx)]);
endmodule

// File: rtl/xpc_data_store.sv
module xpc_data_store #(
    parameter int INDEX_BITS = 10,
    parameter int WORD_BITS  = 2,
    parameter int DATA_W     = 32
) (
    input  logic                          clk,
    input  logic [INDEX_BITS-1:0]         idx,
    output logic [DATA_W*(1<<WORD_BITS)-1:0] rd_line,
    input  logic                          wr_en,
    input  logic [WORD_BITS-1:0]          wr_word,
    input  logic [DATA_W-1:0]             wr_data
);
    localparam int LINES  = 1 << INDEX_BITS;
    localparam int LINE_W = DATA_W * (1 << WORD_BITS);

    logic [LINE_W-1:0] lines [LINES];

    assign rd_line = lines[idx];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            lines[idx][wr_word*DATA_W +: DATA_W] <= wr_data;
        end
    end
endmodule

// File: rtl/xpc_ctrl.sv
module xpc_ctrl
    import xpc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int BYTE_BITS  = 2,
    parameter int WORD_BITS  = 2,
    parameter int BANK_BITS  = 2,
    parameter int INDEX_BITS = 10,
    parameter int TAG_W      = 16,
    parameter int BANK_ID    = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_req,
    input  logic                  cpu_we,
    input  logic [DATA_W-1:0]     cpu_wdata,
    input  logic                  in_match,
    input  logic [WORD_BITS-1:0]  in_word,
    input  logic [INDEX_BITS-1:0] in_idx,
    input  logic [TAG_W-1:0]      in_tag,
    output logic [DATA_W-1:0]     cpu_rdata,
    output logic                  cpu_ready,
    output logic                  cpu_stall,
    output logic [INDEX_BITS-1:0] rq_idx,
    input  logic [TAG_W-1:0]      ts_tag,
    input  logic                  ts_valid,
    input  logic                  ts_shared,
    output logic                  ts_fill_en,
    output logic [TAG_W-1:0]      ts_fill_tag,
    output logic                  ts_fill_shared,
    output logic                  ts_clr_en,
    input  logic [DATA_W*(1<<WORD_BITS)-1:0] dl_line,
    output logic                  dw_en,
    output logic [WORD_BITS-1:0]  dw_word,
    output logic [DATA_W-1:0]     dw_data,
    output logic                  mb_req,
    input  logic                  mb_gnt,
    output logic                  mb_cmd,
    output logic [ADDR_W-1:0]     mb_addr,
    output logic [DATA_W-1:0]     mb_wdata,
    input  logic                  mb_rvalid,
    input  logic [DATA_W-1:0]     mb_rdata,
    input  logic                  mb_rshared
);
    localparam int WORDS = 1 << WORD_BITS;
    localparam logic [WORD_BITS-1:0] LAST_BEAT = WORD_BITS'(WORDS - 1);

    xpc_state_e state_q, state_d;

    logic                 rq_we;
    logic [WORD_BITS-1:0] rq_word;
    logic [TAG_W-1:0]     rq_tag;
    logic [DATA_W-1:0]    rq_wdata;
    logic [WORD_BITS-1:0] beat_q;
    logic [DATA_W-1:0]    rdata_q;
    mb_cmd_e              cmd_q;
    logic                 clr_q;
    logic [WORD_BITS-1:0] bus_word;

    logic hit;
    logic accept, set_fill, set_write, set_clr, cap_hit, beat_adv;

    assign hit = ts_valid && (ts_tag == rq_tag);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        cpu_ready  = 1'b0;
        cpu_stall  = 1'b0;
        mb_req     = 1'b0;
        ts_fill_en = 1'b0;
        ts_clr_en  = 1'b0;
        dw_en      = 1'b0;
        dw_word    = rq_word;
        dw_data    = rq_wdata;
        accept     = 1'b0;
        set_fill   = 1'b0;
        set_write  = 1'b0;
        set_clr    = 1'b0;
        cap_hit    = 1'b0;
        beat_adv   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req && in_match) begin
                    accept  = 1'b1;
                    state_d = ST_LOOKUP;
                end
            end
            ST_LOOKUP: begin
                cpu_stall = 1'b1;
                if (hit) begin
                    if (!rq_we) begin
                        cap_hit = 1'b1;
                        state_d = ST_DONE;
                    end else begin
                        dw_en = 1'b1;
                        if (ts_shared) begin
                            set_write = 1'b1;
                            set_clr   = 1'b1;
                            state_d   = ST_BUSREQ;
                        end else begin
                            state_d = ST_DONE;
                        end
                    end
                end else begin
                    set_write = rq_we;
                    set_fill  = !rq_we;
                    state_d   = ST_BUSREQ;
                end
            end
            ST_BUSREQ: begin
                cpu_stall = 1'b1;
                mb_req    = 1'b1;
                if (mb_gnt) begin
                    if (cmd_q == MB_FILL) begin
                        state_d = ST_FILL;
                    end else begin
                        ts_clr_en = clr_q;
                        state_d   = ST_DONE;
                    end
                end
            end
            ST_FILL: begin
                cpu_stall = 1'b1;
                if (mb_rvalid) begin
                    dw_en    = 1'b1;
                    dw_word  = beat_q;
                    dw_data  = mb_rdata;
                    beat_adv = 1'b1;
                    if (beat_q == LAST_BEAT) begin
                        ts_fill_en = 1'b1;
                        state_d    = ST_DONE;
                    end
                end
            end
            ST_DONE: begin
                cpu_ready = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // request datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq_we    <= 1'b0;
            rq_word  <= '0;
            rq_idx   <= '0;
            rq_tag   <= '0;
            rq_wdata <= '0;
            beat_q   <= '0;
            rdata_q  <= '0;
            cmd_q    <= MB_FILL;
            clr_q    <= 1'b0;
        end else begin
            if (accept) begin
                rq_we    <= cpu_we;
                rq_word  <= in_word;
                rq_idx   <= in_idx;
                rq_tag   <= in_tag;
                rq_wdata <= cpu_wdata;
                beat_q   <= '0;
            end
            if (set_fill) begin
                cmd_q <= MB_FILL;
                clr_q <= 1'b0;
            end
            if (set_write) begin
                cmd_q <= MB_WRITE;
                clr_q <= set_clr;
            end
            if (cap_hit) begin
                rdata_q <= dl_line[rq_word*DATA_W +: DATA_W];
            end
            if (beat_adv) begin
                beat_q <= beat_q + 1'b1;
                if (beat_q == rq_word) begin
                    rdata_q <= mb_rdata;
                end
            end
        end
    end

    assign bus_word       = (cmd_q == MB_FILL) ? '0 : rq_word;
    assign mb_addr        = {rq_tag, rq_idx, BANK_BITS'(BANK_ID), bus_word, {BYTE_BITS{1'b0}}};
    assign mb_cmd         = cmd_q;
    assign mb_wdata       = rq_wdata;
    assign cpu_rdata      = rdata_q;
    assign ts_fill_tag    = rq_tag;
    assign ts_fill_shared = mb_rshared;

    // R4: request held until granted
    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_req && !mb_gnt) |=> mb_req);

    // R3: ready is a single-cycle pulse
    a_r3_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R2: foreign-bank request leaves the slice idle
    a_r2_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cpu_req && !in_match) |=> (!cpu_stall && !mb_req));

    // R5: last fill beat completes the request next cycle
    a_r5_last_beat_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && mb_rvalid && beat_q == LAST_BEAT) |=> cpu_ready);

    // R7: shared write hit goes on the bus as a word write
    a_r7_shared_write_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && rq_we && hit && ts_shared) |=> (mb_req && mb_cmd == MB_WRITE));

    // R6: unshared write hit stays off the bus
    a_r6_local_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && rq_we && hit && !ts_shared) |=> (!mb_req && cpu_ready));
endmodule

// File: rtl/xpc_slice.sv
module xpc_slice #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int BYTE_BITS  = 2,
    parameter int WORD_BITS  = 2,
    parameter int BANK_BITS  = 2,
    parameter int INDEX_BITS = 10,
    parameter int BANK_ID    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              cpu_stall,
    output logic              mb_req,
    input  logic              mb_gnt,
    output logic              mb_cmd,
    output logic [ADDR_W-1:0] mb_addr,
    output logic [DATA_W-1:0] mb_wdata,
    input  logic              mb_rvalid,
    input  logic [DATA_W-1:0] mb_rdata,
    input  logic              mb_rshared,
    input  logic              snp_valid,
    input  logic              snp_write,
    input  logic [ADDR_W-1:0] snp_addr
);
    localparam int TAG_W  = ADDR_W - BYTE_BITS - WORD_BITS - BANK_BITS - INDEX_BITS;
    localparam int LINE_W = DATA_W * (1 << WORD_BITS);

    logic                  in_match;
    logic [WORD_BITS-1:0]  in_word;
    logic [INDEX_BITS-1:0] in_idx;
    logic [TAG_W-1:0]      in_tag;

    logic                  snp_match;
    logic [WORD_BITS-1:0]  snp_word_unused;
    logic [INDEX_BITS-1:0] snp_idx;
    logic [TAG_W-1:0]      snp_tag;

    logic [INDEX_BITS-1:0] rq_idx;
    logic [TAG_W-1:0]      ts_tag;
    logic                  ts_valid, ts_shared;
    logic                  ts_fill_en, ts_fill_shared, ts_clr_en;
    logic [TAG_W-1:0]      ts_fill_tag;
    logic [LINE_W-1:0]     dl_line;
    logic                  dw_en;
    logic [WORD_BITS-1:0]  dw_word;
    logic [DATA_W-1:0]     dw_data;

    xpc_addr_split #(
        .ADDR_W(ADDR_W), .BYTE_BITS(BYTE_BITS), .WORD_BITS(WORD_BITS),
        .BANK_BITS(BANK_BITS), .INDEX_BITS(INDEX_BITS), .TAG_W(TAG_W), .BANK_ID(BANK_ID)
    ) u_cpu_split (
        .addr(cpu_addr), .bank_hit(in_match), .word(in_word), .index(in_idx), .tag(in_tag)
    );

    xpc_addr_split #(
        .ADDR_W(ADDR_W), .BYTE_BITS(BYTE_BITS), .WORD_BITS(WORD_BITS),
        .BANK_BITS(BANK_BITS), .INDEX_BITS(INDEX_BITS), .TAG_W(TAG_W), .BANK_ID(BANK_ID)
    ) u_snp_split (
        .addr(snp_addr), .bank_hit(snp_match), .word(snp_word_unused), .index(snp_idx), .tag(snp_tag)
    );

    xpc_tag_store #(.INDEX_BITS(INDEX_BITS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(rq_idx), .rd_tag(ts_tag), .rd_valid(ts_valid), .rd_shared(ts_shared),
        .fill_en(ts_fill_en), .fill_tag(ts_fill_tag), .fill_shared(ts_fill_shared),
        .clr_en(ts_clr_en),
        .snp_en(snp_valid && snp_match), .snp_write(snp_write),
        .snp_idx(snp_idx), .snp_tag(snp_tag)
    );

    xpc_data_store #(.INDEX_BITS(INDEX_BITS), .WORD_BITS(WORD_BITS), .DATA_W(DATA_W)) u_data (
        .clk(clk), .idx(rq_idx), .rd_line(dl_line),
        .wr_en(dw_en), .wr_word(dw_word), .wr_data(dw_data)
    );

    xpc_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_BITS(BYTE_BITS), .WORD_BITS(WORD_BITS),
        .BANK_BITS(BANK_BITS), .INDEX_BITS(INDEX_BITS), .TAG_W(TAG_W), .BANK_ID(BANK_ID)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
        .in_match(in_match), .in_word(in_word), .in_idx(in_idx), .in_tag(in_tag),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .cpu_stall(cpu_stall),
        .rq_idx(rq_idx),
        .ts_tag(ts_tag), .ts_valid(ts_valid), .ts_shared(ts_shared),
        .ts_fill_en(ts_fill_en), .ts_fill_tag(ts_fill_tag), .ts_fill_shared(ts_fill_shared),
        .ts_clr_en(ts_clr_en),
        .dl_line(dl_line), .dw_en(dw_en), .dw_word(dw_word), .dw_data(dw_data),
        .mb_req(mb_req), .mb_gnt(mb_gnt), .mb_cmd(mb_cmd), .mb_addr(mb_addr),
        .mb_wdata(mb_wdata), .mb_rvalid(mb_rvalid), .mb_rdata(mb_rdata),
        .mb_rshared(mb_rshared)
    );
endmodule

// File: tb/sim_xpc_slice.sv
module sim_xpc_slice;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req, cpu_we;
    logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
    logic        cpu_ready, cpu_stall;
    logic        mb_req, mb_gnt, mb_cmd;
    logic [31:0] mb_addr, mb_wdata, mb_rdata;
    logic        mb_rvalid, mb_rshared;
    logic        snp_valid, snp_write;
    logic [31:0] snp_addr;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xpc_slice #(.BANK_ID(1)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .cpu_stall(cpu_stall),
        .mb_req(mb_req), .mb_gnt(mb_gnt), .mb_cmd(mb_cmd), .mb_addr(mb_addr),
        .mb_wdata(mb_wdata), .mb_rvalid(mb_rvalid), .mb_rdata(mb_rdata),
        .mb_rshared(mb_rshared),
        .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr)
    );

    // bus kind: 0 none, 1 fill, 2 word write
    typedef struct packed {
        logic        we;
        logic        shr;
        logic [1:0]  bus;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 2'd1, 32'h0001_0014, 32'h0,         32'h0001_0015}, // R4 R5 miss
        '{1'b0, 1'b0, 2'd0, 32'h0001_0018, 32'h0,         32'h0001_0019}, // R3 hit
        '{1'b1, 1'b0, 2'd0, 32'h0001_001C, 32'hDEAD_0001, 32'h0},         // R6
        '{1'b0, 1'b0, 2'd0, 32'h0001_001C, 32'h0,         32'hDEAD_0001}, // R6 readback
        '{1'b0, 1'b0, 2'd1, 32'h0002_0010, 32'h0,         32'h0002_0011}, // R5 evict
        '{1'b0, 1'b0, 2'd0, 32'h0002_001C, 32'h0,         32'h0002_001D}, // R5 word 3 kept
        '{1'b1, 1'b0, 2'd2, 32'h0003_0050, 32'h1234_5678, 32'h0},         // R8
        '{1'b0, 1'b0, 2'd1, 32'h0003_0050, 32'h0,         32'h0003_0051}, // R8 no alloc
        '{1'b0, 1'b1, 2'd1, 32'h0004_0090, 32'h0,         32'h0004_0091}, // R9 shared fill
        '{1'b1, 1'b0, 2'd2, 32'h0004_0094, 32'hCAFE_0002, 32'h0},         // R7
        '{1'b1, 1'b0, 2'd0, 32'h0004_0098, 32'hCAFE_0003, 32'h0},         // R7 now unshared
        '{1'b0, 1'b0, 2'd0, 32'h0004_0094, 32'h0,         32'hCAFE_0002}, // R7 data kept
        '{1'b0, 1'b0, 2'd1, 32'h0006_001C, 32'h0,         32'h0006_001D}  // R5 last word
    };

    function automatic logic [31:0] memfn(input logic [31:0] a);
        return {a[31:2], 2'b01};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [31:0] got_data, got_addr, got_wdata;
    int          got_lat, got_bus;
    bit          bad_stall;

    task automatic do_access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                             input logic shr, input int delay);
        int waited = 0;
        int beat = 0;
        bit fill_on = 0;
        bit bubble = 0;
        logic [31:0] line;
        line = {addr[31:4], 4'b0};
        got_bus = 0; got_addr = '0; got_wdata = '0; bad_stall = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        got_lat = 1;
        while (!cpu_ready && got_lat < 200) begin
            if (!cpu_stall) bad_stall = 1;
            mb_gnt = 1'b0; mb_rvalid = 1'b0;
            if (fill_on) begin
                if (beat == 2 && !bubble) begin
                    bubble = 1;
                end else begin
                    mb_rvalid  = 1'b1;
                    mb_rdata   = memfn(line | (32'(beat) << 2));
                    mb_rshared = shr;
                    beat++;
                    if (beat == 4) fill_on = 0;
                end
            end else if (mb_req && got_bus == 0) begin
                if (waited >= delay) begin
                    mb_gnt = 1'b1;
                    got_addr = mb_addr; got_wdata = mb_wdata;
                    if (mb_cmd == 1'b0) begin
                        got_bus = 1; fill_on = 1;
                    end else begin
                        got_bus = 2;
                    end
                end else begin
                    waited++;
                end
            end
            @(negedge clk);
            got_lat++;
        end
        mb_gnt = 1'b0; mb_rvalid = 1'b0; mb_rshared = 1'b0;
        got_data = cpu_rdata;
        @(negedge clk);
        check(!cpu_ready, "R3 ready pulse", 32'(cpu_ready), 32'd0);
    endtask

    task automatic snoop(input logic wr, input logic [31:0] a);
        @(negedge clk);
        snp_valid = 1'b1; snp_write = wr; snp_addr = a;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic expect_result(input logic we, input logic [1:0] bus, input logic [31:0] addr,
                                 input logic [31:0] wd, input logic [31:0] exp, input string tag);
        check(got_bus == int'(bus), {tag, " bus kind"}, 32'(got_bus), 32'(bus));
        if (bus == 2'd1)
            check(got_addr == {addr[31:4], 4'b0}, {tag, " R4 fill address"}, got_addr, {addr[31:4], 4'b0});
        if (bus == 2'd2) begin
            check(got_addr == {addr[31:2], 2'b0}, {tag, " write address"}, got_addr, {addr[31:2], 2'b0});
            check(got_wdata == wd, {tag, " write data"}, got_wdata, wd);
        end
        if (!we)
            check(got_data == exp, {tag, " read data"}, got_data, exp);
        if (bus == 2'd0)
            check(got_lat == 2, {tag, " R3 hit latency"}, 32'(got_lat), 32'd2);
        check(!bad_stall, {tag, " R3 stall while busy"}, 32'(bad_stall), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        mb_gnt = 1'b0; mb_rvalid = 1'b0; mb_rdata = '0; mb_rshared = 1'b0;
        snp_valid = 1'b0; snp_write = 1'b0; snp_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!cpu_ready && !cpu_stall && !mb_req, "R1 idle after reset",
              {29'd0, cpu_ready, cpu_stall, mb_req}, 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            do_access(VECS[i].we, VECS[i].addr, VECS[i].wdata, VECS[i].shr, i % 3);
            expect_result(VECS[i].we, VECS[i].bus, VECS[i].addr, VECS[i].wdata, VECS[i].exp,
                          $sformatf("vec%0d", i));
        end

        // R2 foreign bank request is ignored
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 32'h0006_0004; cpu_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        cpu_req = 1'b0;
        begin
            bit moved = 0;
            for (int k = 0; k < 4; k++) begin
                if (cpu_ready || cpu_stall || mb_req) moved = 1;
                @(negedge clk);
            end
            check(!moved, "R2 foreign bank ignored", 32'(moved), 32'd0);
        end
        do_access(1'b0, 32'h0006_0014, 32'h0, 1'b0, 0);
        expect_result(1'b0, 2'd0, 32'h0006_0014, 32'h0, 32'h0006_0015, "R2 line untouched");

        // R10 snoop with other tag has no effect
        snoop(1'b1, 32'h0007_0010);
        do_access(1'b0, 32'h0006_0018, 32'h0, 1'b0, 0);
        expect_result(1'b0, 2'd0, 32'h0006_0018, 32'h0, 32'h0006_0019, "R10 foreign tag");

        // R9 snooped fill marks line shared
        snoop(1'b0, 32'h0006_0010);
        do_access(1'b1, 32'h0006_0014, 32'h0BAD_0BAD, 1'b0, 1);
        expect_result(1'b1, 2'd2, 32'h0006_0014, 32'h0BAD_0BAD, 32'h0, "R9 snoop share");

        // R10 snooped write invalidates
        snoop(1'b1, 32'h0006_001C);
        do_access(1'b0, 32'h0006_0014, 32'h0, 1'b0, 2);
        expect_result(1'b0, 2'd1, 32'h0006_0014, 32'h0, 32'h0006_0015, "R10 invalidate");

        // R1 reset clears valid lines
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!cpu_ready && !cpu_stall && !mb_req, "R1 idle in reset",
              {29'd0, cpu_ready, cpu_stall, mb_req}, 32'd0);
        rst_n = 1'b1;
        do_access(1'b0, 32'h0004_0094, 32'h0, 1'b0, 0);
        expect_result(1'b0, 2'd1, 32'h0004_0094, 32'h0, 32'h0004_0095, "R1 invalid after reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule